// File: doc/BRIEF.md
# Block-Counted Audio Playback Fetch Engine

This block pulls audio data out of memory one 32-byte block at a time and hands each block downstream as a single wide beat. Software loads a block-aligned start address as two 16-bit halves and then writes a control word. That word carries a run bit and a 15-bit block count. While the run bit is set, the engine reads consecutive blocks through a request/acknowledge memory port. It keeps a single read outstanding and moves its pointer forward one block per acknowledge. A live counter shows how many blocks of the current pass are still to be fetched.

When the last block of a pass has been handed off, the engine raises a one-cycle interrupt pulse. If the run bit is still set at that point, it reloads the start address and block count and plays the buffer again. Clearing the run bit lets the block in flight finish and then parks the engine. The start address is held in a double-buffered pair of shadow halves. A new address replaces the committed one only when both halves have been written, in either order.

Top module: `audio_blk_dma`

## Requirements
- R1: After reset, mem_req, out_valid and irq are low, and all four readback selections return 0.
- R2: A write to only one address half leaves the committed start address, as read back on selections 0 (upper half) and 1 (lower half), unchanged. Once the other half is also written, in either order, the two halves are committed together.
- R3: The low 5 bits of the committed start address always read as zero, and every mem_addr issued has its low 5 bits at zero.
- R4: Writing the control word (selection 2) with bit 15 set and bits 14:0 equal to zero issues no memory request, and the count readback (selection 3) stays 0.
- R5: With bit 15 set and a count N in bits 14:0, the engine issues requests at start, start+32, …, start+32·(N−1). Only one request is outstanding at a time, and mem_addr holds steady until the request is acknowledged.
- R6: On the cycle after the engine starts, the count readback (selection 3) shows N. It then drops by one on each acknowledged block.
- R7: Each acknowledged block appears as exactly one out_valid beat carrying the fetched data. The beat holds steady while out_ready is low, and no new request is issued until the beat is taken.
- R8: irq pulses high for exactly one cycle, on the cycle after the beat of the last block of a pass is taken.
- R9: If bit 15 is still set when a pass ends, the next request goes to the start address again, and the count is reloaded.
- R10: If bit 15 is cleared while a block is in flight, that block is still fetched and delivered. No further request follows, no irq is raised and the count readback holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 upper address half, 1 lower address half, 2 control word |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 2 | Readback select: 0 upper address, 1 lower address, 2 control word, 3 remaining blocks |
| rd_data | output | 16 | Readback data (combinational) |
| mem_req | output | 1 | Block read request |
| mem_addr | output | 32 | Byte address of the requested block |
| mem_ack | input | 1 | Request accepted, mem_rdata valid |
| mem_rdata | input | 256 | Block read data |
| out_valid | output | 1 | Fetched block available |
| out_ready | input | 1 | Downstream accepts the block |
| out_data | output | 256 | Fetched block |
| irq | output | 1 | One-cycle end-of-pass pulse |

## Verification
A corrupted block pointer shows up on the very next request as a wrong mem_addr. Because each beat carries data derived from the address that was acknowledged, it also shows up at the output one cycle later. A counter that is off by one is visible on the count readback right away. It also moves the irq pulse, or the wrap back to the start address, one block early or late within the same pass. A stuck shadow-valid flag shows up on the address readback right after the first single-half write, before any transfer is started.

// File: rtl/audio_blk_dma_pkg.sv
package audio_blk_dma_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_SEND = 2'd2
   } fetch_st_e;

   localparam logic [1:0] SEL_ADDR_UP  = 2'd0;
   localparam logic [1:0] SEL_ADDR_DN  = 2'd1;
   localparam logic [1:0] SEL_CTRL     = 2'd2;
   localparam logic [1:0] SEL_LEFT     = 2'd3;

endpackage

// File: rtl/abd_addr_shadow.sv
module abd_addr_shadow #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 16,
   parameter int OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_up,
   input  logic              wr_dn,
   input  logic [REG_W-1:0]  wr_data,
   output logic [ADDR_W-1:0] start_addr
);

   localparam int HALVES = 2;

   if (ADDR_W != HALVES * REG_W) begin : g_bad_split
      $error("abd_addr_shadow: ADDR_W must be twice REG_W");
   end
   if (OFS_W >= REG_W) begin : g_bad_ofs
      $error("abd_addr_shadow: OFS_W must be below REG_W");
   end

   logic                  commit;
   logic [ADDR_W-1:0]     merged;
   logic [ADDR_W-1:0]     start_q;

   // index 0 = lower half, index 1 = upper half
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic             wr_h;
      logic             vld_q;
      logic [REG_W-1:0] sh_q;
      logic [REG_W-1:0] nxt;
      logic             full;

      assign wr_h = (h == 0) ? wr_dn : wr_up;
      assign nxt  = wr_h ? wr_data : sh_q;
      assign full = wr_h | vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            sh_q  <= '0;
         end else begin
            if (wr_h) sh_q <= wr_data;
            if (commit)    vld_q <= 1'b0;
            else if (wr_h) vld_q <= 1'b1;
         end
      end
   end

   assign commit = g_half[0].full & g_half[1].full & (wr_up | wr_dn);
   assign merged = {g_half[1].nxt, g_half[0].nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (commit) begin
         start_q <= {merged[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      end
   end

   assign start_addr = start_q;

   AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_addr[OFS_W-1:0] == '0); // R3

   AST_HALF_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_up && !wr_dn && !g_half[0].vld_q) |=> $stable(start_addr)); // R2

endmodule

// File: rtl/abd_fetch_fsm.sv
module abd_fetch_fsm
   import audio_blk_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 15,
   parameter int OFS_W  = 5,
   parameter int DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CNT_W-1:0]  blocks,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [CNT_W-1:0]  left,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFS_W;

   if (DATA_W != (8 << OFS_W)) begin : g_bad_data
      $error("abd_fetch_fsm: DATA_W must equal one block of bytes");
   end

   fetch_st_e         st_q;
   logic [ADDR_W-1:0] cur_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] data_q;
   logic              irq_q;
   logic              go;

   assign go = run && (blocks != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         cur_q  <= '0;
         left_q <= '0;
         data_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         unique case (st_q)
            FS_IDLE: begin
               if (go) begin
                  cur_q  <= start_addr;
                  left_q <= blocks;
                  st_q   <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (mem_ack) begin
                  data_q <= mem_rdata;
                  cur_q  <= cur_q + STEP;
                  left_q <= left_q - 1'b1;
                  st_q   <= FS_SEND;
               end
            end
            FS_SEND: begin
               if (out_ready) begin
                  if (left_q == '0) begin
                     irq_q <= 1'b1;
                     if (go) begin
                        cur_q  <= start_addr;
                        left_q <= blocks;
                        st_q   <= FS_REQ;
                     end else begin
                        st_q <= FS_IDLE;
                     end
                  end else begin
                     st_q <= run ? FS_REQ : FS_IDLE;
                  end
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q == FS_REQ);
   assign mem_addr  = cur_q;
   assign out_valid = (st_q == FS_SEND);
   assign out_data  = data_q;
   assign left      = left_q;
   assign irq       = irq_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5

   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFS_W-1:0] == '0)); // R3

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

   AST_LEFT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (left == $past(left) - 1'b1)); // R6

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8

   AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(out_valid) && $past(out_ready) && ($past(left) == '0))); // R8

endmodule

// File: rtl/audio_blk_dma.sv
module audio_blk_dma
   import audio_blk_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 16,
   parameter int BLK_BYTES = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [1:0]             wr_sel,
   input  logic [REG_W-1:0]       wr_data,
   input  logic [1:0]             rd_sel,
   output logic [REG_W-1:0]       rd_data,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   input  logic                   mem_ack,
   input  logic [BLK_BYTES*8-1:0] mem_rdata,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [BLK_BYTES*8-1:0] out_data,
   output logic                   irq
);

   localparam int OFS_W  = $clog2(BLK_BYTES);
   localparam int DATA_W = BLK_BYTES * 8;
   localparam int CNT_W  = REG_W - 1;

   if ((1 << OFS_W) != BLK_BYTES) begin : g_bad_blk
      $error("audio_blk_dma: BLK_BYTES must be a power of two");
   end

   logic [REG_W-1:0]  ctrl_q;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0]  left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && (wr_sel == SEL_CTRL)) begin
         ctrl_q <= wr_data;
      end
   end

   abd_addr_shadow #(
      .ADDR_W (ADDR_W),
      .REG_W  (REG_W),
      .OFS_W  (OFS_W)
   ) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_up      (wr_en && (wr_sel == SEL_ADDR_UP)),
      .wr_dn      (wr_en && (wr_sel == SEL_ADDR_DN)),
      .wr_data    (wr_data),
      .start_addr (start_addr)
   );

   abd_fetch_fsm #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl_q[REG_W-1]),
      .blocks     (ctrl_q[CNT_W-1:0]),
      .start_addr (start_addr),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .left       (left),
      .irq        (irq)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_ADDR_UP: rd_data = start_addr[ADDR_W-1:REG_W];
         SEL_ADDR_DN: rd_data = start_addr[REG_W-1:0];
         SEL_CTRL:    rd_data = ctrl_q;
         default:     rd_data = {{(REG_W-CNT_W){1'b0}}, left};
      endcase
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && out_valid)); // R5

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && !out_valid && !ctrl_q[REG_W-1]) |=> !mem_req); // R10

endmodule

// File: tb/audio_blk_dma_tb.sv
`timescale 1ns/1ps
module audio_blk_dma_tb;

   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [15:0]   wr_data = '0;
   logic [1:0]    rd_sel = '0;
   logic [15:0]   rd_data;
   logic          mem_req;
   logic [31:0]   mem_addr;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   int n_ack    = 0;
   int n_beat   = 0;
   int n_irq    = 0;
   int lat      = 0;
   int wcnt     = 0;
   logic [31:0] last_ack_addr = '0;
   logic [31:0] addr_log [0:63];

   always #5 clk = ~clk;

   audio_blk_dma u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // memory model and stream monitor, all on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) n_irq++;
         if (out_valid && out_ready) begin
            n_beat++;
            chk(out_data == {8{last_ack_addr}}, "R7 beat data", out_data[63:0], {2{last_ack_addr}});
         end
         if (mem_req) begin
            if (wcnt >= lat) begin
               mem_ack = 1'b1;
               mem_rdata = {8{mem_addr}};
               last_ack_addr = mem_addr;
               if (n_ack < 64) addr_log[n_ack] = mem_addr;
               n_ack++;
               wcnt = 0;
            end else begin
               mem_ack = 1'b0;
               wcnt++;
            end
         end else begin
            mem_ack = 1'b0;
         end
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         chk(v == 16'h0, "R1 readback", v, 0);
      end
   endtask

   task automatic t_shadow;
      logic [15:0] v;
      wr(2'd0, 16'h1234);
      rd(2'd0, v); chk(v == 16'h0000, "R2 upper half alone", v, 16'h0000);
      wr(2'd1, 16'h567F);
      rd(2'd0, v); chk(v == 16'h1234, "R2 upper after pair", v, 16'h1234);
      rd(2'd1, v); chk(v == 16'h5660, "R3 lower masked", v, 16'h5660);
      wr(2'd1, 16'h0040);
      rd(2'd1, v); chk(v == 16'h5660, "R2 lower half alone", v, 16'h5660);
      wr(2'd0, 16'h0002);
      rd(2'd0, v); chk(v == 16'h0002, "R2 reversed order upper", v, 16'h0002);
      rd(2'd1, v); chk(v == 16'h0040, "R2 reversed order lower", v, 16'h0040);
   endtask

   task automatic t_zero_len;
      logic [15:0] v;
      int a0 = n_ack;
      wr(2'd2, 16'h8000);
      repeat (10) @(negedge clk);
      chk(n_ack == a0, "R4 no request", n_ack, a0);
      chk(mem_req == 1'b0, "R4 mem_req low", mem_req, 0);
      rd(2'd3, v); chk(v == 16'h0, "R4 count stays 0", v, 0);
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_play;
      logic [15:0] v;
      int a0 = n_ack;
      int i0 = n_irq;
      int guard = 0;
      logic [31:0] exp_a [0:4];
      exp_a[0] = 32'h0002_0040; exp_a[1] = 32'h0002_0060; exp_a[2] = 32'h0002_0080;
      exp_a[3] = 32'h0002_00A0; exp_a[4] = 32'h0002_0040;
      lat = 0; out_ready = 1'b1;
      wr(2'd2, 16'h8004);
      while (n_irq == i0 && guard < 200) begin
         @(negedge clk); #1; guard++;
      end
      chk(n_irq == i0 + 1, "R8 irq seen", n_irq, i0 + 1);
      chk(n_ack - a0 == 5, "R8 irq after last beat, next pass begun", n_ack - a0, 5);
      // disable while the first block of the second pass is in flight
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0000;
      @(negedge clk); wr_en = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_ack - a0 == 5, "R10 stop after in-flight block", n_ack - a0, 5);
      chk(n_irq == i0 + 1, "R8 single pulse", n_irq, i0 + 1);
      for (int k = 0; k < 5; k++) begin
         chk(addr_log[a0 + k] == exp_a[k], (k == 4) ? "R9 wrap to start" : "R5 address sequence",
             addr_log[a0 + k], exp_a[k]);
      end
      rd(2'd3, v); chk(v == 16'd3, "R6 reloaded count less one", v, 3);
      chk(mem_req == 1'b0, "R10 parked", mem_req, 0);
   endtask

   task automatic t_count;
      logic [15:0] v;
      logic [DW-1:0] held;
      int a0, i0;
      int guard = 0;
      wr(2'd0, 16'h0010);
      wr(2'd1, 16'h0000);
      a0 = n_ack; i0 = n_irq;
      lat = 3; wcnt = 0; out_ready = 1'b0;
      wr(2'd2, 16'h8003);
      @(negedge clk);
      rd(2'd3, v); chk(v == 16'd3, "R6 count loaded", v, 3);
      while (!out_valid && guard < 50) begin
         @(negedge clk); guard++;
      end
      rd(2'd3, v); chk(v == 16'd2, "R6 count after one ack", v, 2);
      held = out_data;
      chk(held == {8{32'h0010_0000}}, "R7 first beat data", held[63:0], {2{32'h0010_0000}});
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R7 beat held", out_valid, 1);
      chk(out_data == held, "R7 data stable", out_data[63:0], held[63:0]);
      chk(mem_req == 1'b0, "R7 no request while beat waits", mem_req, 0);
      wr(2'd2, 16'h0003);
      out_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk(n_ack - a0 == 1, "R10 one block only", n_ack - a0, 1);
      chk(n_irq == i0, "R10 no irq", n_irq, i0);
      rd(2'd3, v); chk(v == 16'd2, "R10 count held", v, 2);
      chk(mem_req == 1'b0 && out_valid == 1'b0, "R10 idle", {mem_req, out_valid}, 0);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_shadow;
      t_zero_len;
      t_play;
      t_count;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule